// File: doc/BRIEF.md
# Indirect-Addressed Register Port

This block is the slave register interface of a small host-controller-style peripheral. A host reaches it through only two 16-bit bus locations: a command location and a data location. The host first writes a register index to the command location, and the same byte carries a flag that says whether the next data transfers are writes or reads. It then moves one or two 16-bit words through the data location. Registers in the low index range are 32 bits wide and are carried as two halves, low half first. Registers from index 0x20 upward are 16 bits wide and take a single transfer.

Behind the port sit a control word, a sticky interrupt-status word, a shared interrupt mask, a scratch word, a buffer-length word, a read-only revision and chip identifier, and a buffer-status word. The buffer-status word mirrors two flags from the transfer engine. A keyed software-reset location returns the register state to its defaults. The block drives an interrupt line whenever a status bit and its mask bit are both set.

Top module: `irp_top`

## Requirements
- R1: A command write keeps only bits 7:0 of the data word. Bits 6:0 are the register index and bit 7 is the write flag. The write clears the word pointer. A read of the command location returns `{8'h00, command byte}`.
- R2: Indices below 0x20 are 32 bits wide and take two data transfers, low half first. A wide write updates the register only when the high half arrives. A new command write discards a pending low half.
- R3: A wide read captures the whole register on its first transfer. The second transfer returns the captured high half, even if the register changes in between.
- R4: Indices 0x20 and above take a single data transfer and do not use the word pointer.
- R5: A data write is ignored when the write flag is clear. Writes to read-only or unmapped indices change nothing. Reads of unmapped indices return zero.
- R6: Index 0x00 reads `{24'h0, REV}` and index 0x27 reads `{8'h61, CHIP_REV}`. Both are read-only.
- R7: Scratch (0x28) and buffer length (0x2B) are read/write 16-bit words. They reset to 0x0000 and 0x1000 respectively.
- R8: Writing ones to 0x04 sets bits of the interrupt mask, and writing ones to 0x05 clears them. Both indices read back the mask.
- R9: An `int_evt` bit sets the matching bit of status (0x03). That bit stays set until the host writes a one to it. An event in the same cycle as the clear wins. `irq` is high while any bit is set in both status and mask.
- R10: Buffer status (0x2C) reads `buf_full` in bit 2 and `buf_done` in bit 5. All other bits read zero.
- R11: Writing exactly 0x00F6 to 0x29 restores control, mask, status, scratch and buffer length to their defaults in the next cycle. Any other value written there is ignored, and the index reads zero.
- R12: Accesses may come in consecutive clock cycles. `bus_rdata` is updated at the edge that samples a read strobe and holds its value otherwise.
- R13: Control (0x01) is a 32-bit read/write register that drives `ctrl_q` and resets to `CTRL_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Access strobe, one cycle per transfer |
| bus_wr | input | 1 | 1 = write transfer, 0 = read transfer |
| bus_a0 | input | 1 | 0 = command location, 1 = data location |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| int_evt | input | INT_W | Interrupt event pulses from the engine |
| buf_full | input | 1 | Transfer buffer full flag |
| buf_done | input | 1 | Transfer buffer done flag |
| ctrl_q | output | 32 | Control register contents |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle. The first is a hardware event setting a status bit. The second is the host committing a write-one-to-clear of that same bit, which takes effect on the cycle of the high-half write of index 0x03. The bench raises `int_evt` for that bit in exactly the cycle of the high-half write, then reads the status back. The bit must still be set. A second clear with no event must then zero it. A similar overlap is tested for wide reads: an event arrives between the low-half and high-half reads, and the high half must not show it until the next full read.

// File: rtl/irp_pkg.sv
// Package: shared constants and helpers for the indirect register port.
// Assumes a 7-bit register index; the index map is fixed by the bus protocol.
package irp_pkg;

    localparam int CMD_W     = 8;
    localparam int IDX_W     = 7;
    localparam int WIDE_LIM  = 32;   // indices below this are two-word registers

    localparam logic [IDX_W-1:0] IDX_REV     = 7'h00;
    localparam logic [IDX_W-1:0] IDX_CTRL    = 7'h01;
    localparam logic [IDX_W-1:0] IDX_STAT    = 7'h03;
    localparam logic [IDX_W-1:0] IDX_MSET    = 7'h04;
    localparam logic [IDX_W-1:0] IDX_MCLR    = 7'h05;
    localparam logic [IDX_W-1:0] IDX_CHIPID  = 7'h27;
    localparam logic [IDX_W-1:0] IDX_SCRATCH = 7'h28;
    localparam logic [IDX_W-1:0] IDX_SWRST   = 7'h29;
    localparam logic [IDX_W-1:0] IDX_BUFLEN  = 7'h2B;
    localparam logic [IDX_W-1:0] IDX_BUFSTAT = 7'h2C;

    localparam logic [15:0] SWRST_KEY  = 16'h00F6;
    localparam logic [7:0]  CHIP_MAGIC = 8'h61;
    localparam int          BSTAT_FULL = 2;
    localparam int          BSTAT_DONE = 5;

    // One decoded bus transfer
    typedef struct packed {
        logic cmd_wr;
        logic cmd_rd;
        logic dat_wr;
        logic dat_rd;
    } irp_xfer_t;

    // True when an index selects a two-word register
    function automatic logic is_wide(input logic [IDX_W-1:0] idx);
        return (int'(idx) < WIDE_LIM);
    endfunction

endpackage

// File: rtl/irp_sequencer.sv
// Module: command latch and word sequencer.
// Holds the command byte and the word pointer, assembles two-word writes,
// snapshots two-word reads, and registers the read data.
// Assumes one-cycle strobes; any spacing between strobes is accepted.
module irp_sequencer #(
    parameter int BUS_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_cs,
    input  logic                          bus_wr,
    input  logic                          bus_a0,
    input  logic [BUS_W-1:0]              bus_wdata,
    input  logic [2*BUS_W-1:0]            rd_val,
    output logic [irp_pkg::IDX_W-1:0]     cmd_idx,
    output logic                          cmd_flag,
    output logic                          cmd_wr_o,
    output logic                          ptr_q,
    output logic                          commit,
    output logic [2*BUS_W-1:0]            commit_data,
    output logic [BUS_W-1:0]              bus_rdata
);
    import irp_pkg::*;

    localparam int REG_W = 2 * BUS_W;

    irp_xfer_t            xf;
    logic [CMD_W-1:0]     cmd_q;
    logic [BUS_W-1:0]     hold_q;
    logic [BUS_W-1:0]     snap_q;
    logic                 wide;

    // Decode the bus strobe into one of four transfer kinds
    always_comb begin
        xf.cmd_wr = bus_cs &  bus_wr & ~bus_a0;
        xf.cmd_rd = bus_cs & ~bus_wr & ~bus_a0;
        xf.dat_wr = bus_cs &  bus_wr &  bus_a0;
        xf.dat_rd = bus_cs & ~bus_wr &  bus_a0;
    end

    assign cmd_idx  = cmd_q[IDX_W-1:0];
    assign cmd_flag = cmd_q[CMD_W-1];
    assign cmd_wr_o = xf.cmd_wr;
    assign wide     = is_wide(cmd_idx);

    // Commit a write when the last word of the register arrives under a write flag
    always_comb begin
        commit      = xf.dat_wr && cmd_flag && (!wide || ptr_q);
        commit_data = wide ? {bus_wdata, hold_q} : {{(REG_W-BUS_W){1'b0}}, bus_wdata};
    end

    // Command byte latch
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (xf.cmd_wr)
            cmd_q <= bus_wdata[CMD_W-1:0];
    end

    // Word pointer: cleared by a command, toggled by wide data transfers
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= 1'b0;
        else if (xf.cmd_wr)
            ptr_q <= 1'b0;
        else if (wide && (xf.dat_rd || (xf.dat_wr && cmd_flag)))
            ptr_q <= ~ptr_q;
    end

    // Low-half holding register for wide writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (xf.dat_wr && cmd_flag && wide && !ptr_q)
            hold_q <= bus_wdata;
    end

    // High-half snapshot for wide reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (xf.dat_rd && wide && !ptr_q)
            snap_q <= rd_val[REG_W-1:BUS_W];
    end

    // Registered read data, updated only by read strobes
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (xf.cmd_rd)
            bus_rdata <= {{(BUS_W-CMD_W){1'b0}}, cmd_q};
        else if (xf.dat_rd)
            bus_rdata <= (wide && ptr_q) ? snap_q : rd_val[BUS_W-1:0];
    end

endmodule

// File: rtl/irp_intr.sv
// Module: sticky interrupt status and shared enable mask.
// Events set status bits; host ones clear them; an event beats a clear.
// The mask is set and cleared through two separate write locations.
module irp_intr #(
    parameter int INT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [INT_W-1:0] evt,
    input  logic             wr_stat,
    input  logic             wr_mset,
    input  logic             wr_mclr,
    input  logic [INT_W-1:0] wdata,
    output logic [INT_W-1:0] stat_q,
    output logic [INT_W-1:0] mask_q,
    output logic             irq
);

    // Per-bit sticky status with event priority
    generate
        for (genvar i = 0; i < INT_W; i++) begin : g_stat
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_q[i] <= 1'b0;
                else if (soft_rst)
                    stat_q[i] <= evt[i];
                else
                    stat_q[i] <= evt[i] | (stat_q[i] & ~(wr_stat & wdata[i]));
            end
        end
    endgenerate

    // Shared enable mask: set location ORs, clear location AND-NOTs
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            mask_q <= '0;
        else if (wr_mset)
            mask_q <= mask_q | wdata;
        else if (wr_mclr)
            mask_q <= mask_q & ~wdata;
    end

    // Interrupt request from enabled pending bits
    always_comb irq = |(stat_q & mask_q);

endmodule

// File: rtl/irp_regbank.sv
// Module: register storage, write decode, keyed soft reset and read mux.
// Takes committed full-width writes from the sequencer; all storage is
// returned to defaults by the reset key. Unmapped indices read zero.
module irp_regbank #(
    parameter int          BUS_W      = 16,
    parameter int          INT_W      = 32,
    parameter logic [31:0] CTRL_RST   = 32'h0,
    parameter logic [15:0] BUFLEN_RST = 16'h1000,
    parameter logic [7:0]  REV        = 8'h10,
    parameter logic [7:0]  CHIP_REV   = 8'h00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [irp_pkg::IDX_W-1:0] idx,
    input  logic                      commit,
    input  logic [2*BUS_W-1:0]        commit_data,
    input  logic [INT_W-1:0]          int_evt,
    input  logic                      buf_full,
    input  logic                      buf_done,
    output logic [2*BUS_W-1:0]        rd_val,
    output logic [2*BUS_W-1:0]        ctrl_q,
    output logic [INT_W-1:0]          stat_q,
    output logic [INT_W-1:0]          mask_q,
    output logic [BUS_W-1:0]          scratch_q,
    output logic                      soft_rst,
    output logic                      irq
);
    import irp_pkg::*;

    localparam int REG_W = 2 * BUS_W;

    logic [BUS_W-1:0] buflen_q;
    logic             wr_ctrl, wr_stat, wr_mset, wr_mclr, wr_scr, wr_blen;

    // Decode committed writes by index
    always_comb begin
        wr_ctrl  = commit && (idx == IDX_CTRL);
        wr_stat  = commit && (idx == IDX_STAT);
        wr_mset  = commit && (idx == IDX_MSET);
        wr_mclr  = commit && (idx == IDX_MCLR);
        wr_scr   = commit && (idx == IDX_SCRATCH);
        wr_blen  = commit && (idx == IDX_BUFLEN);
        soft_rst = commit && (idx == IDX_SWRST) && (commit_data[15:0] == SWRST_KEY);
    end

    // Control, scratch and buffer-length storage
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q    <= CTRL_RST;
            scratch_q <= '0;
            buflen_q  <= BUFLEN_RST;
        end else begin
            if (wr_ctrl) ctrl_q    <= commit_data;
            if (wr_scr)  scratch_q <= commit_data[BUS_W-1:0];
            if (wr_blen) buflen_q  <= commit_data[BUS_W-1:0];
        end
    end

    irp_intr #(.INT_W(INT_W)) u_intr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .evt      (int_evt),
        .wr_stat  (wr_stat),
        .wr_mset  (wr_mset),
        .wr_mclr  (wr_mclr),
        .wdata    (commit_data[INT_W-1:0]),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    // Read multiplexer over the current index
    always_comb begin
        rd_val = '0;
        case (idx)
            IDX_REV:     rd_val = {{(REG_W-8){1'b0}}, REV};
            IDX_CTRL:    rd_val = ctrl_q;
            IDX_STAT:    rd_val = REG_W'(stat_q);
            IDX_MSET,
            IDX_MCLR:    rd_val = REG_W'(mask_q);
            IDX_CHIPID:  rd_val = REG_W'({CHIP_MAGIC, CHIP_REV});
            IDX_SCRATCH: rd_val = REG_W'(scratch_q);
            IDX_BUFLEN:  rd_val = REG_W'(buflen_q);
            IDX_BUFSTAT: begin
                rd_val[BSTAT_FULL] = buf_full;
                rd_val[BSTAT_DONE] = buf_done;
            end
            default:     rd_val = '0;
        endcase
    end

endmodule

// File: rtl/irp_top.sv
// Module: top of the indirect register port.
// Joins the command/word sequencer to the register bank. The bus is a
// single-cycle strobe interface; read data is registered.
module irp_top #(
    parameter int          INT_W      = 32,
    parameter logic [31:0] CTRL_RST   = 32'h0,
    parameter logic [15:0] BUFLEN_RST = 16'h1000,
    parameter logic [7:0]  REV        = 8'h10,
    parameter logic [7:0]  CHIP_REV   = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs,
    input  logic             bus_wr,
    input  logic             bus_a0,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic [INT_W-1:0] int_evt,
    input  logic             buf_full,
    input  logic             buf_done,
    output logic [31:0]      ctrl_q,
    output logic             irq
);
    localparam int BUS_W = 16;

    logic [irp_pkg::IDX_W-1:0] cmd_idx;
    logic                      cmd_flag, cmd_wr, seq_ptr, commit, soft_rst;
    logic [2*BUS_W-1:0]        commit_data, rd_val;
    logic [INT_W-1:0]          int_stat, int_mask;
    logic [BUS_W-1:0]          scratch;

    irp_sequencer #(.BUS_W(BUS_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_cs      (bus_cs),
        .bus_wr      (bus_wr),
        .bus_a0      (bus_a0),
        .bus_wdata   (bus_wdata),
        .rd_val      (rd_val),
        .cmd_idx     (cmd_idx),
        .cmd_flag    (cmd_flag),
        .cmd_wr_o    (cmd_wr),
        .ptr_q       (seq_ptr),
        .commit      (commit),
        .commit_data (commit_data),
        .bus_rdata   (bus_rdata)
    );

    irp_regbank #(
        .BUS_W      (BUS_W),
        .INT_W      (INT_W),
        .CTRL_RST   (CTRL_RST),
        .BUFLEN_RST (BUFLEN_RST),
        .REV        (REV),
        .CHIP_REV   (CHIP_REV)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (cmd_idx),
        .commit      (commit),
        .commit_data (commit_data),
        .int_evt     (int_evt),
        .buf_full    (buf_full),
        .buf_done    (buf_done),
        .rd_val      (rd_val),
        .ctrl_q      (ctrl_q),
        .stat_q      (int_stat),
        .mask_q      (int_mask),
        .scratch_q   (scratch),
        .soft_rst    (soft_rst),
        .irq         (irq)
    );

endmodule

// File: rtl/irp_checker.sv
// Module: protocol and state checks for irp_top, attached by bind.
module irp_checker #(
    parameter int          INT_W    = 32,
    parameter logic [31:0] CTRL_RST = 32'h0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_cs,
    input logic             bus_wr,
    input logic             bus_a0,
    input logic [15:0]      bus_rdata,
    input logic [INT_W-1:0] int_evt,
    input logic [31:0]      ctrl_q,
    input logic             cmd_wr,
    input logic             seq_ptr,
    input logic             commit,
    input logic [6:0]       cmd_idx,
    input logic [31:0]      commit_data,
    input logic             soft_rst,
    input logic [INT_W-1:0] int_stat,
    input logic [INT_W-1:0] int_mask,
    input logic [15:0]      scratch
);

    // A command write leaves the word pointer at the low half
    p_ptr_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !seq_ptr);

    // A commit only happens on a data-location write strobe
    p_commit_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (bus_cs && bus_wr && bus_a0));

    // A wide register commits only with the high half
    p_wide_high_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_idx < 7'h20) |-> seq_ptr);

    // Events are captured in status
    p_event_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|int_evt) |=> ((int_stat & $past(int_evt)) == $past(int_evt)));

    // Mask-set writes leave the written ones set
    p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_idx == 7'h04) |=>
            ((int_mask & $past(commit_data[INT_W-1:0])) == $past(commit_data[INT_W-1:0])));

    // Soft reset restores defaults one cycle later
    p_soft_defaults_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (int_mask == '0 && scratch == '0 && ctrl_q == CTRL_RST));

    // Scratch only changes on a commit
    p_scratch_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(scratch));

    // Read data only changes after a read strobe
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind irp_top irp_checker #(.INT_W(INT_W), .CTRL_RST(CTRL_RST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_cs      (bus_cs),
    .bus_wr      (bus_wr),
    .bus_a0      (bus_a0),
    .bus_rdata   (bus_rdata),
    .int_evt     (int_evt),
    .ctrl_q      (ctrl_q),
    .cmd_wr      (cmd_wr),
    .seq_ptr     (seq_ptr),
    .commit      (commit),
    .cmd_idx     (cmd_idx),
    .commit_data (commit_data),
    .soft_rst    (soft_rst),
    .int_stat    (int_stat),
    .int_mask    (int_mask),
    .scratch     (scratch)
);

// File: tb/irp_top_tb.sv
// Bench: sweeps of the register map against an arithmetic model, plus
// directed corner cases for sequencing, collisions and soft reset.
module irp_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_wr = 1'b0, bus_a0 = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] int_evt = '0;
    logic        buf_full = 1'b0, buf_done = 1'b0;
    logic [31:0] ctrl_q;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // Bench model of the register state
    logic [31:0] m_ctrl, m_stat, m_mask;
    logic [15:0] m_scr, m_blen;

    irp_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
        .bus_a0(bus_a0), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_evt(int_evt), .buf_full(buf_full), .buf_done(buf_done),
        .ctrl_q(ctrl_q), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 32'h0; m_stat = 32'h0; m_mask = 32'h0;
        m_scr = 16'h0; m_blen = 16'h1000;
    endtask

    task automatic model_wr(input int idx, input logic [31:0] v);
        logic [31:0] w;
        w = (idx < 32) ? v : {16'h0, v[15:0]};
        case (idx)
            1:    m_ctrl = w;
            3:    m_stat = m_stat & ~w;
            4:    m_mask = m_mask | w;
            5:    m_mask = m_mask & ~w;
            40:   m_scr  = w[15:0];
            41:   if (w[15:0] == 16'h00F6) model_reset();
            43:   m_blen = w[15:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_rd(input int idx);
        case (idx)
            0:  return 32'h10;
            1:  return m_ctrl;
            3:  return m_stat;
            4, 5: return m_mask;
            39: return 32'h6100;
            40: return {16'h0, m_scr};
            43: return {16'h0, m_blen};
            44: return {26'h0, buf_done, 2'b0, buf_full, 2'b0};
            default: return 32'h0;
        endcase
    endfunction

    // One bus transfer; entered and left at a falling edge
    task automatic acc(input logic a0, input logic wr, input logic [15:0] d);
        bus_cs = 1'b1; bus_a0 = a0; bus_wr = wr; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input int idx, input logic [31:0] v);
        acc(1'b0, 1'b1, 16'(idx) | 16'h0080);
        acc(1'b1, 1'b1, v[15:0]);
        if (idx < 32) acc(1'b1, 1'b1, v[31:16]);
        model_wr(idx, v);
    endtask

    task automatic rd_reg(input int idx, output logic [31:0] v);
        acc(1'b0, 1'b1, 16'(idx));
        acc(1'b1, 1'b0, 16'h0);
        v = {16'h0, bus_rdata};
        if (idx < 32) begin
            acc(1'b1, 1'b0, 16'h0);
            v[31:16] = bus_rdata;
        end
    endtask

    task automatic pulse_evt(input logic [31:0] e);
        int_evt = e;
        @(negedge clk);
        int_evt = '0;
        m_stat = m_stat | e;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] keep;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R13, R7, R12)
        chk("R13 ctrl reset", ctrl_q, 32'h0);
        chk("R12 rdata reset", {16'h0, bus_rdata}, 32'h0);
        chk("R9 irq reset", {31'h0, irq}, 32'h0);
        rd_reg(43, v); chk("R7 buflen reset", v, 32'h1000);

        // R6 identification registers
        rd_reg(39, v); chk("R6 chip id", v & 32'hFF00, 32'h6100);
        rd_reg(0, v);  chk("R6 revision", v, 32'h10);

        // R1 command upper byte ignored, read-back of command byte
        acc(1'b0, 1'b1, 16'hFF28);
        acc(1'b0, 1'b0, 16'h0);
        chk("R1 command readback", {16'h0, bus_rdata}, 32'h0028);

        // R5 data write with flag clear is ignored
        acc(1'b1, 1'b1, 16'hDEAD);
        rd_reg(40, v); chk("R5 flag clear write ignored", v, 32'h0);

        // R7 scratch walking ones, R4 single transfer
        for (int b = 0; b < 16; b++) begin
            wr_reg(40, 32'(16'h1 << b));
            rd_reg(40, v); chk("R7 scratch walk", v, 32'(16'h1 << b));
        end

        // R2/R13 wide write commits only with the high half
        acc(1'b0, 1'b1, 16'h0081);
        acc(1'b1, 1'b1, 16'h1111);
        chk("R2 low half pending", ctrl_q, 32'h0);
        acc(1'b1, 1'b1, 16'h2222);
        chk("R13 ctrl written", ctrl_q, 32'h2222_1111);
        acc(1'b0, 1'b1, 16'h0081);
        acc(1'b1, 1'b1, 16'h3333);
        acc(1'b0, 1'b1, 16'h0081);
        acc(1'b1, 1'b1, 16'h4444);
        acc(1'b1, 1'b1, 16'h5555);
        chk("R2 pending half dropped by command", ctrl_q, 32'h5555_4444);
        m_ctrl = 32'h5555_4444;

        // R12 read data holds across writes
        rd_reg(40, v);
        keep = bus_rdata;
        wr_reg(40, 32'hBEEF);
        chk("R12 rdata held", {16'h0, bus_rdata}, {16'h0, keep});

        // R3 snapshot: event between low and high half reads
        acc(1'b0, 1'b1, 16'h0003);
        acc(1'b1, 1'b0, 16'h0);
        chk("R3 low half", {16'h0, bus_rdata}, 32'h0);
        pulse_evt(32'h0010_0000);
        acc(1'b1, 1'b0, 16'h0);
        chk("R3 high half from snapshot", {16'h0, bus_rdata}, 32'h0);
        rd_reg(3, v); chk("R3 new snapshot", v, 32'h0010_0000);

        // R8/R9 mask and irq
        wr_reg(4, 32'h0010_0000);
        chk("R9 irq asserted", {31'h0, irq}, 32'h1);
        rd_reg(5, v); chk("R8 mask via clear index", v, 32'h0010_0000);
        wr_reg(5, 32'h0010_0000);
        chk("R8 mask cleared irq low", {31'h0, irq}, 32'h0);
        rd_reg(4, v); chk("R8 mask read", v, 32'h0);
        wr_reg(3, 32'h0010_0000);
        rd_reg(3, v); chk("R9 write one clears", v, 32'h0);

        // R9 collision: event in the cycle of the clearing commit
        pulse_evt(32'h8);
        acc(1'b0, 1'b1, 16'h0083);
        acc(1'b1, 1'b1, 16'h0008);
        int_evt = 32'h8;
        acc(1'b1, 1'b1, 16'h0000);
        int_evt = '0;
        rd_reg(3, v); chk("R9 event beats clear", v, 32'h8);
        wr_reg(3, 32'h8);
        rd_reg(3, v); chk("R9 clear without event", v, 32'h0);

        // R10 buffer status combinations
        for (int k = 0; k < 4; k++) begin
            buf_full = k[0]; buf_done = k[1];
            rd_reg(44, v);
            chk("R10 buffer status", v, {26'h0, k[1], 2'b0, k[0], 2'b0});
        end
        buf_full = 1'b0; buf_done = 1'b0;

        // R11 soft reset key
        wr_reg(40, 32'h1234);
        wr_reg(4, 32'h0000_00F0);
        wr_reg(41, 32'h00F7);
        rd_reg(40, v); chk("R11 wrong key ignored", v, 32'h1234);
        wr_reg(41, 32'h00F6);
        chk("R11 ctrl default", ctrl_q, 32'h0);
        rd_reg(40, v); chk("R11 scratch default", v, 32'h0);
        rd_reg(4, v);  chk("R11 mask default", v, 32'h0);
        rd_reg(43, v); chk("R11 buflen default", v, 32'h1000);
        rd_reg(41, v); chk("R11 key index reads zero", v, 32'h0);

        // R5/R4/R2 sweep: write every index, then read every index
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 128; i++)
                wr_reg(i, {16'hC300 | 16'(i) | 16'(pass << 12), 16'h5A00 | 16'(i) ^ 16'(pass << 8)});
            for (int i = 0; i < 128; i++) begin
                rd_reg(i, v);
                chk("R5 sweep read", v, exp_rd(i));
            end
        end

        summary();
        $finish;
    end

endmodule